// File: doc/BRIEF.md
# Sector FIFO DMA bridge

This block is a circular byte buffer placed between a host-side DMA port and a disk-side DMA port. Its capacity is a whole number of 512-byte sectors, 16 of them by default, which gives 8192 bytes. Two control inputs pick which side produces data and which side consumes it. The host port can fill the buffer while the disk drains it, or the disk can fill it while the host drains it. Data moves in beats of `BEAT_BYTES` bytes, four by default, and each port uses a valid/ready handshake.

Two free-running byte counters track the buffer, one for writes and one for reads. The occupancy is their difference. The buffer position is the counter value modulo the capacity, so a burst that runs past the last entry carries on at offset zero. A status word reports the level in whole sectors. In host-write direction it reports free sectors instead, together with an idle flag. Three registered interrupt causes show whether the buffer is empty, holds data, or is full.

A host transfer starts with a size in bytes. The block counts accepted host beats and pulses a completion strobe when the count reaches that size. Attempts to write into a full buffer or to read from an empty one are refused, and each such attempt sets a sticky error flag.

Top module: `sector_fifo_bridge`

## Requirements
- R1: After reset the level is 0. `irq_empty` is 1. `irq_data`, `irq_full`, `err_ovf`, `err_unf` and `host_done` are 0.
- R2: Beats leave the buffer in the order they entered. This holds for bursts that wrap past the end of the buffer: the buffer position is the byte counter modulo 8192.
- R3: The level never exceeds the capacity of 8192 bytes. When the buffer is full, producer ready is low and the level does not change. When it is empty, consumer valid is low.
- R4: When `host_wr_dir`=1, the host input port is the producer. It accepts beats only while `host_dma_en`=1 and a host transfer is active. The disk output port is the consumer, and only while `disk_dma_en`=1 and `disk_rd_dir`=0.
- R5: When `host_wr_dir`=0, the disk input port is the producer, and only while `disk_dma_en`=1 and `disk_rd_dir`=1. The host output port is the consumer, and only while `host_dma_en`=1 and a host transfer is active.
- R6: Let S be the level divided by 512, rounded down. When `host_wr_dir`=1, `stat_count` is 16−S and `stat_empty_flag` is 1 exactly when the level is 0. When `host_wr_dir`=0, `stat_count` is S and `stat_empty_flag` is 0.
- R7: `irq_empty` is 1 exactly when the level is 0, and `irq_data` is 1 exactly when the level is not 0. Both change on the same clock edge as the level.
- R8: `irq_full` is 1 exactly when the level equals 8192 bytes.
- R9: A `host_req_start` pulse loads `host_req_size` in bytes and clears the transferred count. Each accepted host beat adds 4 bytes. On the edge where the count reaches the size, the transfer ends and `host_done` is 1 for the next cycle. A size of 0 gives `host_done` in the next cycle with no beats.
- R10: `err_ovf` is set when the selected producer offers a beat while the buffer is full. `err_unf` is set when the selected consumer is ready while the buffer is empty. Only reset clears either flag.
- R11: A port that the direction does not select sees ready or valid held at 0, and its data has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_dir | input | 1 | 1: host fills, disk drains; 0: disk fills, host drains |
| disk_rd_dir | input | 1 | Disk is set to deliver data into the buffer |
| host_dma_en | input | 1 | Host DMA enable |
| disk_dma_en | input | 1 | Disk DMA enable |
| host_req_start | input | 1 | Begin a host transfer |
| host_req_size | input | 14 | Host transfer size in bytes |
| host_in_valid | input | 1 | Host beat offered |
| host_in_data | input | 32 | Host beat data |
| host_in_ready | output | 1 | Host beat accepted |
| host_out_valid | output | 1 | Beat available to host |
| host_out_data | output | 32 | Beat data to host |
| host_out_ready | input | 1 | Host takes beat |
| disk_in_valid | input | 1 | Disk beat offered |
| disk_in_data | input | 32 | Disk beat data |
| disk_in_ready | output | 1 | Disk beat accepted |
| disk_out_valid | output | 1 | Beat available to disk |
| disk_out_data | output | 32 | Beat data to disk |
| disk_out_ready | input | 1 | Disk takes beat |
| stat_count | output | 8 | Sector count, occupied or free depending on direction |
| stat_empty_flag | output | 1 | Idle flag in host-write direction |
| fifo_level | output | 14 | Level in bytes |
| irq_empty | output | 1 | Empty cause |
| irq_data | output | 1 | Data-present cause |
| irq_full | output | 1 | Full cause |
| host_done | output | 1 | Host transfer complete strobe |
| err_ovf | output | 1 | Sticky write-when-full flag |
| err_unf | output | 1 | Sticky read-when-empty flag |

## Verification
Ready and valid are combinational, because they depend only on the registered level and the control inputs. The bench therefore drives inputs at the falling edge and samples the handshake one nanosecond later, in the same cycle. The level, the status word, the three interrupt causes and the error flags all change on the rising edge that accepts the beat or the refused attempt. `host_done` follows the final beat by exactly one edge. Each task samples these results at the falling edge right after the edge concerned. That places every check half a cycle away from the edge at which the value was produced.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   localparam int STAT_W = 8;
   typedef enum logic [1:0] {
      PORT_IDLE = 2'd0,
      PORT_HOST = 2'd1,
      PORT_DISK = 2'd2
   } sfb_port_e;
endpackage

// File: rtl/sfb_store.sv
module sfb_store #(
   parameter int DW = 32,
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sfb_ptrs.sv
module sfb_ptrs #(
   parameter int CNT_W      = 14,
   parameter int BEAT_BYTES = 4,
   parameter int CAP_BYTES  = 8192,
   localparam int BEAT_LOG  = $clog2(BEAT_BYTES),
   localparam int AW        = CNT_W - 1 - BEAT_LOG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [AW-1:0]    wr_addr,
   output logic [AW-1:0]    rd_addr,
   output logic [CNT_W-1:0] occ,
   output logic [CNT_W-1:0] occ_nxt,
   output logic             full,
   output logic             empty
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(BEAT_BYTES);
   localparam logic [CNT_W-1:0] CAP  = CNT_W'(CAP_BYTES);

   logic [CNT_W-1:0] wr_cnt, rd_cnt, wr_nxt, rd_nxt;

   always_comb begin
      wr_nxt  = push ? wr_cnt + STEP : wr_cnt;
      rd_nxt  = pop  ? rd_cnt + STEP : rd_cnt;
      occ_nxt = wr_nxt - rd_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt <= '0;
         rd_cnt <= '0;
      end else begin
         wr_cnt <= wr_nxt;
         rd_cnt <= rd_nxt;
      end
   end

   assign occ     = wr_cnt - rd_cnt;
   assign full    = (occ == CAP);
   assign empty   = (occ == '0);
   assign wr_addr = wr_cnt[CNT_W-2:BEAT_LOG];
   assign rd_addr = rd_cnt[CNT_W-2:BEAT_LOG];

   p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CAP);
   p_occ_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == $past(occ)) || (occ == $past(occ) + STEP) || (occ == $past(occ) - STEP));
endmodule

// File: rtl/sfb_status.sv
module sfb_status #(
   parameter int CNT_W        = 14,
   parameter int CAP_BYTES    = 8192,
   parameter int SECTOR_BYTES = 512,
   parameter int NUM_SECTORS  = 16,
   localparam int SEC_LOG     = $clog2(SECTOR_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr_dir,
   input  logic [CNT_W-1:0]           occ,
   input  logic [CNT_W-1:0]           occ_nxt,
   output logic [sfb_pkg::STAT_W-1:0] stat_count,
   output logic                       stat_empty_flag,
   output logic                       irq_empty,
   output logic                       irq_data,
   output logic                       irq_full
);
   import sfb_pkg::*;
   localparam logic [CNT_W-1:0]  CAP     = CNT_W'(CAP_BYTES);
   localparam logic [STAT_W-1:0] ALL_SEC = STAT_W'(NUM_SECTORS);

   logic [CNT_W-SEC_LOG-1:0] sectors;
   assign sectors = occ[CNT_W-1:SEC_LOG];

   always_comb begin
      if (host_wr_dir) begin
         stat_count      = ALL_SEC - STAT_W'(sectors);
         stat_empty_flag = (occ == '0);
      end else begin
         stat_count      = STAT_W'(sectors);
         stat_empty_flag = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_empty <= 1'b1;
         irq_data  <= 1'b0;
         irq_full  <= 1'b0;
      end else begin
         if (occ_nxt == '0) begin
            irq_data <= 1'b0;
            if (!irq_empty) irq_empty <= 1'b1;
         end else begin
            irq_empty <= 1'b0;
            if (!irq_data) irq_data <= 1'b1;
         end
         irq_full <= (occ_nxt == CAP);
      end
   end

   p_empty_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_empty == (occ == '0));
   p_cause_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({irq_empty, irq_data}) == 1);
   p_full_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_full == (occ == CAP));
endmodule

// File: rtl/sfb_req.sv
module sfb_req #(
   parameter int CNT_W      = 14,
   parameter int BEAT_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] size,
   input  logic             beat,
   output logic             active,
   output logic             done
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(BEAT_BYTES);
   logic [CNT_W-1:0] moved, target;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         moved  <= '0;
         target <= '0;
         active <= 1'b0;
         done   <= 1'b0;
      end else if (start) begin
         moved  <= '0;
         target <= size;
         active <= (size != '0);
         done   <= (size == '0);
      end else if (beat && active) begin
         moved <= moved + STEP;
         if (moved + STEP >= target) begin
            active <= 1'b0;
            done   <= 1'b1;
         end else begin
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !active);
endmodule

// File: rtl/sector_fifo_bridge.sv
module sector_fifo_bridge #(
   parameter int NUM_SECTORS  = 16,
   parameter int SECTOR_BYTES = 512,
   parameter int BEAT_BYTES   = 4,
   localparam int CAP_BYTES   = NUM_SECTORS * SECTOR_BYTES,
   localparam int CNT_W       = $clog2(CAP_BYTES) + 1,
   localparam int DW          = 8 * BEAT_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr_dir,
   input  logic             disk_rd_dir,
   input  logic             host_dma_en,
   input  logic             disk_dma_en,
   input  logic             host_req_start,
   input  logic [CNT_W-1:0] host_req_size,
   input  logic             host_in_valid,
   input  logic [DW-1:0]    host_in_data,
   output logic             host_in_ready,
   output logic             host_out_valid,
   output logic [DW-1:0]    host_out_data,
   input  logic             host_out_ready,
   input  logic             disk_in_valid,
   input  logic [DW-1:0]    disk_in_data,
   output logic             disk_in_ready,
   output logic             disk_out_valid,
   output logic [DW-1:0]    disk_out_data,
   input  logic             disk_out_ready,
   output logic [7:0]       stat_count,
   output logic             stat_empty_flag,
   output logic [CNT_W-1:0] fifo_level,
   output logic             irq_empty,
   output logic             irq_data,
   output logic             irq_full,
   output logic             host_done,
   output logic             err_ovf,
   output logic             err_unf
);
   import sfb_pkg::*;
   localparam int BEAT_LOG = $clog2(BEAT_BYTES);
   localparam int AW       = CNT_W - 1 - BEAT_LOG;

   generate
      if ((1 << $clog2(CAP_BYTES)) != CAP_BYTES) begin : g_bad_cap
         $error("capacity must be a power of two");
      end
      if ((1 << BEAT_LOG) != BEAT_BYTES || BEAT_BYTES > SECTOR_BYTES) begin : g_bad_beat
         $error("beat size must be a power of two not above a sector");
      end
      if (NUM_SECTORS > 255) begin : g_bad_stat
         $error("sector count must fit the status byte");
      end
   endgenerate

   sfb_port_e src, dst;
   logic req_active, full, empty, push, pop, in_valid, out_ready;
   logic [DW-1:0] in_data, rd_data;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [CNT_W-1:0] occ, occ_nxt;

   always_comb begin
      src = PORT_IDLE;
      dst = PORT_IDLE;
      if (host_wr_dir) begin
         if (host_dma_en && req_active)  src = PORT_HOST;
         if (disk_dma_en && !disk_rd_dir) dst = PORT_DISK;
      end else begin
         if (disk_dma_en && disk_rd_dir) src = PORT_DISK;
         if (host_dma_en && req_active)  dst = PORT_HOST;
      end
   end

   always_comb begin
      unique case (src)
         PORT_HOST: begin in_valid = host_in_valid; in_data = host_in_data; end
         PORT_DISK: begin in_valid = disk_in_valid; in_data = disk_in_data; end
         default:   begin in_valid = 1'b0;          in_data = host_in_data; end
      endcase
      unique case (dst)
         PORT_HOST: out_ready = host_out_ready;
         PORT_DISK: out_ready = disk_out_ready;
         default:   out_ready = 1'b0;
      endcase
   end

   assign host_in_ready  = (src == PORT_HOST) && !full;
   assign disk_in_ready  = (src == PORT_DISK) && !full;
   assign host_out_valid = (dst == PORT_HOST) && !empty;
   assign disk_out_valid = (dst == PORT_DISK) && !empty;
   assign host_out_data  = rd_data;
   assign disk_out_data  = rd_data;
   assign push = in_valid && !full;
   assign pop  = out_ready && !empty;
   assign fifo_level = occ;

   sfb_store #(.DW(DW), .AW(AW)) u_store (
      .clk(clk), .wr_en(push), .wr_addr(wr_addr), .wr_data(in_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   sfb_ptrs #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES), .CAP_BYTES(CAP_BYTES)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
      .wr_addr(wr_addr), .rd_addr(rd_addr), .occ(occ), .occ_nxt(occ_nxt),
      .full(full), .empty(empty)
   );

   sfb_status #(.CNT_W(CNT_W), .CAP_BYTES(CAP_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
                .NUM_SECTORS(NUM_SECTORS)) u_status (
      .clk(clk), .rst_n(rst_n), .host_wr_dir(host_wr_dir), .occ(occ), .occ_nxt(occ_nxt),
      .stat_count(stat_count), .stat_empty_flag(stat_empty_flag),
      .irq_empty(irq_empty), .irq_data(irq_data), .irq_full(irq_full)
   );

   sfb_req #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_req (
      .clk(clk), .rst_n(rst_n), .start(host_req_start), .size(host_req_size),
      .beat((host_in_valid && host_in_ready) || (host_out_valid && host_out_ready)),
      .active(req_active), .done(host_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_ovf <= 1'b0;
         err_unf <= 1'b0;
      end else begin
         if (in_valid && full)   err_ovf <= 1'b1;
         if (out_ready && empty) err_unf <= 1'b1;
      end
   end

   p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |=> err_ovf);
   p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_unf |=> err_unf);
   p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_full |-> !host_in_ready && !disk_in_ready);
   p_hostwr_ports_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_dir |-> !disk_in_ready && !host_out_valid);
   p_hostrd_ports_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !host_wr_dir |-> !host_in_ready && !disk_out_valid);
   p_one_side_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({host_in_ready, disk_in_ready}) && $onehot0({host_out_valid, disk_out_valid}));
endmodule

// File: tb/sector_fifo_bridge_tb.sv
module sector_fifo_bridge_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_wr_dir = 1'b1, disk_rd_dir = 1'b0, host_dma_en = 1'b0, disk_dma_en = 1'b0;
   logic host_req_start = 1'b0;
   logic [13:0] host_req_size = '0;
   logic host_in_valid = 1'b0, host_out_ready = 1'b0, disk_in_valid = 1'b0, disk_out_ready = 1'b0;
   logic [31:0] host_in_data = '0, disk_in_data = '0;
   logic host_in_ready, host_out_valid, disk_in_ready, disk_out_valid;
   logic [31:0] host_out_data, disk_out_data;
   logic [7:0] stat_count;
   logic stat_empty_flag, irq_empty, irq_data, irq_full, host_done, err_ovf, err_unf;
   logic [13:0] fifo_level;

   int checks = 0, failures = 0, wr_idx = 0, rd_idx = 0;

   always #2.5 clk = ~clk;

   sector_fifo_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr_dir(host_wr_dir), .disk_rd_dir(disk_rd_dir),
      .host_dma_en(host_dma_en), .disk_dma_en(disk_dma_en),
      .host_req_start(host_req_start), .host_req_size(host_req_size),
      .host_in_valid(host_in_valid), .host_in_data(host_in_data), .host_in_ready(host_in_ready),
      .host_out_valid(host_out_valid), .host_out_data(host_out_data), .host_out_ready(host_out_ready),
      .disk_in_valid(disk_in_valid), .disk_in_data(disk_in_data), .disk_in_ready(disk_in_ready),
      .disk_out_valid(disk_out_valid), .disk_out_data(disk_out_data), .disk_out_ready(disk_out_ready),
      .stat_count(stat_count), .stat_empty_flag(stat_empty_flag), .fifo_level(fifo_level),
      .irq_empty(irq_empty), .irq_data(irq_data), .irq_full(irq_full),
      .host_done(host_done), .err_ovf(err_ovf), .err_unf(err_unf)
   );

   function automatic logic [31:0] pat(int i);
      return 32'hA5C30000 ^ (32'(i) * 32'h00010003);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic req_start(int size);
      @(negedge clk);
      host_req_start = 1'b1;
      host_req_size = 14'(size);
      @(negedge clk);
      host_req_start = 1'b0;
   endtask

   task automatic push_host(int n, string tag);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         host_in_valid = 1'b1;
         host_in_data = pat(wr_idx);
         #1;
         if (!host_in_ready) bad++;
         @(posedge clk);
         wr_idx++;
      end
      @(negedge clk);
      host_in_valid = 1'b0;
      chk(tag, 32'(bad), 32'd0);
   endtask

   task automatic push_disk(int n, string tag);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         disk_in_valid = 1'b1;
         disk_in_data = pat(wr_idx);
         #1;
         if (!disk_in_ready) bad++;
         @(posedge clk);
         wr_idx++;
      end
      @(negedge clk);
      disk_in_valid = 1'b0;
      chk(tag, 32'(bad), 32'd0);
   endtask

   task automatic pop_disk(int n, string tag);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         disk_out_ready = 1'b1;
         #1;
         if (!disk_out_valid || disk_out_data !== pat(rd_idx)) bad++;
         @(posedge clk);
         rd_idx++;
      end
      @(negedge clk);
      disk_out_ready = 1'b0;
      chk(tag, 32'(bad), 32'd0);
   endtask

   task automatic pop_host(int n, string tag);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         host_out_ready = 1'b1;
         #1;
         if (!host_out_valid || host_out_data !== pat(rd_idx)) bad++;
         @(posedge clk);
         rd_idx++;
      end
      @(negedge clk);
      host_out_ready = 1'b0;
      chk(tag, 32'(bad), 32'd0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 level", 32'(fifo_level), 32'd0);
      chk("R1 irq_empty", 32'(irq_empty), 32'd1);
      chk("R1 irq_data/full", {30'd0, irq_data, irq_full}, 32'd0);
      chk("R1 errors/done", {29'd0, err_ovf, err_unf, host_done}, 32'd0);
      chk("R6 idle status host-write", {23'd0, stat_empty_flag, stat_count}, {23'd0, 1'b1, 8'd16});
   endtask

   task automatic t_host_fill();
      host_dma_en = 1'b1;
      req_start(2048);
      push_host(100, "R4 host producer ready");
      chk("R6 partial sector", {23'd0, stat_empty_flag, stat_count}, {23'd0, 1'b0, 8'd16});
      chk("R7 data cause", {30'd0, irq_empty, irq_data}, 32'd1);
      push_host(412, "R4 host producer ready");
      chk("R9 done pulse", 32'(host_done), 32'd1);
      @(negedge clk);
      chk("R9 done single", 32'(host_done), 32'd0);
      chk("R6 free sectors", 32'(stat_count), 32'd12);
      chk("R4 disk consumer off", 32'(disk_out_valid), 32'd0);
   endtask

   task automatic t_disk_drain();
      disk_dma_en = 1'b1;
      disk_rd_dir = 1'b0;
      pop_disk(512, "R2 order host-write");
      chk("R7 empty again", {30'd0, irq_empty, irq_data}, 32'd2);
      disk_dma_en = 1'b0;
   endtask

   task automatic t_full_wrap();
      req_start(8192);
      push_host(2048, "R2 wrap fill");
      chk("R8 full cause", 32'(irq_full), 32'd1);
      chk("R3 level at cap", 32'(fifo_level), 32'd8192);
      chk("R6 none free", {23'd0, stat_empty_flag, stat_count}, 32'd0);
      req_start(4);
      @(negedge clk);
      host_in_valid = 1'b1;
      host_in_data = 32'hDEAD0000;
      #1;
      chk("R3 blocked when full", 32'(host_in_ready), 32'd0);
      @(negedge clk);
      host_in_valid = 1'b0;
      chk("R10 overflow flag", 32'(err_ovf), 32'd1);
      chk("R3 level held", 32'(fifo_level), 32'd8192);
      disk_dma_en = 1'b1;
      pop_disk(2048, "R2 wrap drain order");
      chk("R8 full cleared", 32'(irq_full), 32'd0);
      #1;
      chk("R3 no valid when empty", 32'(disk_out_valid), 32'd0);
      disk_out_ready = 1'b1;
      @(negedge clk);
      disk_out_ready = 1'b0;
      chk("R10 underflow flag", 32'(err_unf), 32'd1);
      req_start(0);
      chk("R9 zero size done", 32'(host_done), 32'd1);
      @(negedge clk);
      chk("R10 flags stay", {30'd0, err_ovf, err_unf}, 32'd3);
      disk_dma_en = 1'b0;
   endtask

   task automatic t_disk_fill_host_drain();
      host_wr_dir = 1'b0;
      disk_rd_dir = 1'b1;
      disk_dma_en = 1'b1;
      @(negedge clk);
      chk("R6 read direction empty", {23'd0, stat_empty_flag, stat_count}, 32'd0);
      host_in_valid = 1'b1;
      host_in_data = 32'h0BAD0BAD;
      #1;
      chk("R11 host input unselected", 32'(host_in_ready), 32'd0);
      @(negedge clk);
      host_in_valid = 1'b0;
      chk("R11 level unchanged", 32'(fifo_level), 32'd0);
      push_disk(1, "R5 disk producer ready");
      chk("R7 data after one beat", {30'd0, irq_empty, irq_data}, 32'd1);
      push_disk(599, "R5 disk producer ready");
      chk("R6 occupied sectors", {23'd0, stat_empty_flag, stat_count}, 32'd4);
      chk("R5 host idle without request", 32'(host_out_valid), 32'd0);
      req_start(2400);
      pop_host(600, "R2 order host-read");
      chk("R9 host read done", 32'(host_done), 32'd1);
      disk_rd_dir = 1'b0;
      @(negedge clk);
      disk_in_valid = 1'b1;
      #1;
      chk("R5 disk not set to deliver", 32'(disk_in_ready), 32'd0);
      @(negedge clk);
      disk_in_valid = 1'b0;
      chk("R11 level after ignored beat", 32'(fifo_level), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      t_reset();
      t_host_fill();
      t_disk_drain();
      t_full_wrap();
      t_disk_fill_host_drain();
      summary();
   end
endmodule